// File: doc/BRIEF.md
# Status Readback Packet Builder

This block answers a host's status readback command by sending a fixed eight-word record over a 32-bit word stream. It watches a command strobe with an 8-bit opcode. Two opcodes are accepted and both give the same record: the primary status opcode and its alias 0x31. The record starts with a constant header word. Five general status words follow, then one packed self-test word, then a constant footer word.

The status inputs are copied into holding registers at the moment a record begins. Every word of one record therefore comes from the same instant, even if the inputs change while the record is being sent. Words leave one at a time under a valid/ready handshake, and the last flag marks the footer.

A request that arrives while a record is in flight is remembered. It is served as soon as the current footer has been transferred, with no idle cycle in between. Several requests that arrive during one record are merged into a single follow-up record.

Top module: `stpkt_top`

## Requirements
- R1: While reset is asserted and after it is released with no request, `tx_valid` and `tx_last` are low.
- R2: A request is a cycle with `cmd_strobe` high and `cmd_opcode` equal to the primary opcode (default 0x30) or the alias 0x31. Both opcodes give identical records. A cycle with any other opcode, or with the strobe low, produces no word at the output.
- R3: A record is exactly eight words in this order: the header constant (default 0xC0DE0A11), general status words 0 to 4, the self-test word, and the footer constant (default 0xE0F055AA). General status word i is `gen_status[32*i+31:32*i]`.
- R4: In the self-test word, `st_busy` is bit 13, `st_detail` is bits 12:5 and `st_flags` is bits 4:0. Bits 31:14 are zero.
- R5: When the block is idle, a request accepted at a clock edge makes the header appear with `tx_valid` high right after that edge.
- R6: A word is consumed only at an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: `tx_last` is high only while the footer word is presented.
- R8: All status inputs are captured at the edge where a record begins. Later changes to the inputs do not alter that record.
- R9: A request that arrives during a record is served right after the footer transfer, and its header follows in the next cycle. Any number of requests during one record give exactly one extra record.
- R10: A request in the same cycle as the footer transfer starts the next record at once, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_strobe | input | 1 | Command present this cycle |
| cmd_opcode | input | 8 | Command opcode |
| gen_status | input | 160 | Five general status words, word 0 in the low bits |
| st_busy | input | 1 | Self-test running |
| st_detail | input | 8 | Self-test detail code |
| st_flags | input | 5 | Self-test result flags |
| tx_ready | input | 1 | Downstream can take a word |
| tx_data | output | 32 | Current record word |
| tx_valid | output | 1 | `tx_data` is a valid word |
| tx_last | output | 1 | Current word is the footer |

## Verification
The header of a record started from idle is due one clock edge after the request edge. Each later word is due one edge after the handshake on the previous word. A queued record's header is due one edge after the footer transfer, so a back-to-back pair keeps `tx_valid` high for sixteen straight cycles when `tx_ready` stays high. The bench drives all inputs and samples all outputs on the falling edge. It decides at each falling edge whether the presented word will transfer at the next rising edge, and it scores that word against a queue of expected records. It checks the no-gap cases by counting falling edges from the request.

// File: rtl/stpkt_pkg.sv
package stpkt_pkg;
    localparam int WORD_W     = 32;
    localparam int DATA_WORDS = 6;
    localparam int GEN_WORDS  = DATA_WORDS - 1;
    localparam int PKT_WORDS  = DATA_WORDS + 2;
    localparam int IDX_W      = $clog2(PKT_WORDS);
    localparam int OPC_W      = 8;
    localparam int DET_W      = 8;
    localparam int FLG_W      = 5;
    localparam int SELF_W     = 1 + DET_W + FLG_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } seq_state_e;

    // busy above detail above flags, zero-filled above
    function automatic word_t pack_selftest(
        input logic             busy,
        input logic [DET_W-1:0] detail,
        input logic [FLG_W-1:0] flags
    );
        word_t w;
        w = '0;
        w[SELF_W-1:0] = {busy, detail, flags};
        return w;
    endfunction
endpackage

// File: rtl/stpkt_decode.sv
module stpkt_decode
    import stpkt_pkg::*;
#(
    parameter int                           N_OPS = 2,
    parameter logic [N_OPS-1:0][OPC_W-1:0]  OPS   = {8'h31, 8'h30}
) (
    input  logic             strobe,
    input  logic [OPC_W-1:0] opcode,
    output logic             hit
);
    logic [N_OPS-1:0] match;

    // one comparator per accepted opcode
    for (genvar g = 0; g < N_OPS; g++) begin : g_cmp
        assign match[g] = (opcode == OPS[g]);
    end

    assign hit = strobe && (|match);
endmodule

// File: rtl/stpkt_snapshot.sv
module stpkt_snapshot
    import stpkt_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [GEN_WORDS*WORD_W-1:0]     gen_in,
    input  logic                            busy_in,
    input  logic [DET_W-1:0]                detail_in,
    input  logic [FLG_W-1:0]                flags_in,
    output logic [DATA_WORDS-1:0][WORD_W-1:0] words_o
);
    typedef struct packed {
        logic [DATA_WORDS-1:0][WORD_W-1:0] w;
    } snap_t;

    snap_t                             snap_d, snap_q;
    logic [DATA_WORDS-1:0][WORD_W-1:0] cap_w;

    for (genvar g = 0; g < GEN_WORDS; g++) begin : g_gen
        assign cap_w[g] = gen_in[g*WORD_W +: WORD_W];
    end
    assign cap_w[DATA_WORDS-1] = pack_selftest(busy_in, detail_in, flags_in);

    always_comb begin
        snap_d = snap_q;
        if (load) begin
            snap_d.w = cap_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign words_o = snap_q.w;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(words_o)); // R8
endmodule

// File: rtl/stpkt_seq.sv
module stpkt_seq
    import stpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_hit,
    input  logic             out_ready,
    output logic             snap_load,
    output logic             out_valid,
    output logic             out_last,
    output logic [IDX_W-1:0] word_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             pend;
    } seq_t;

    seq_t seq_d, seq_q;
    logic xfer;

    assign xfer = (seq_q.st == ST_SEND) && out_ready;

    always_comb begin
        seq_d     = seq_q;
        snap_load = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_hit) begin
                    seq_d.st   = ST_SEND;
                    seq_d.idx  = '0;
                    seq_d.pend = 1'b0;
                    snap_load  = 1'b1;
                end
            end
            ST_SEND: begin
                seq_d.pend = seq_q.pend | req_hit;
                if (xfer) begin
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.idx  = '0;
                        seq_d.pend = 1'b0;
                        if (seq_q.pend || req_hit) begin
                            snap_load = 1'b1;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, idx: '0, pend: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign out_valid = (seq_q.st == ST_SEND);
    assign out_last  = out_valid && (seq_q.idx == LAST_IDX);
    assign word_idx  = seq_q.idx;

    AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && seq_q.pend) |=> (out_valid && word_idx == '0)); // R9
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && req_hit) |=> (out_valid && word_idx == '0)); // R5
endmodule

// File: rtl/stpkt_top.sv
module stpkt_top
    import stpkt_pkg::*;
#(
    parameter logic [OPC_W-1:0]  OP_MAIN  = 8'h30,
    parameter logic [OPC_W-1:0]  OP_ALIAS = 8'h31,
    parameter logic [WORD_W-1:0] HDR_WORD = 32'hC0DE_0A11,
    parameter logic [WORD_W-1:0] FTR_WORD = 32'hE0F0_55AA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_strobe,
    input  logic [OPC_W-1:0]            cmd_opcode,
    input  logic [GEN_WORDS*WORD_W-1:0] gen_status,
    input  logic                        st_busy,
    input  logic [DET_W-1:0]            st_detail,
    input  logic [FLG_W-1:0]            st_flags,
    input  logic                        tx_ready,
    output logic [WORD_W-1:0]           tx_data,
    output logic                        tx_valid,
    output logic                        tx_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

    logic                              req_hit;
    logic                              snap_load;
    logic [IDX_W-1:0]                  word_idx;
    logic [DATA_WORDS-1:0][WORD_W-1:0] held_words;

    stpkt_decode #(
        .N_OPS (2),
        .OPS   ({OP_ALIAS, OP_MAIN})
    ) u_dec (
        .strobe (cmd_strobe),
        .opcode (cmd_opcode),
        .hit    (req_hit)
    );

    stpkt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hit   (req_hit),
        .out_ready (tx_ready),
        .snap_load (snap_load),
        .out_valid (tx_valid),
        .out_last  (tx_last),
        .word_idx  (word_idx)
    );

    stpkt_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (snap_load),
        .gen_in    (gen_status),
        .busy_in   (st_busy),
        .detail_in (st_detail),
        .flags_in  (st_flags),
        .words_o   (held_words)
    );

    always_comb begin
        if (word_idx == '0) begin
            tx_data = HDR_WORD;
        end else if (word_idx == LAST_IDX) begin
            tx_data = FTR_WORD;
        end else begin
            tx_data = held_words[word_idx - 1'b1];
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
    AST_LAST_IS_FOOTER: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |-> (tx_data == FTR_WORD)); // R7
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R7
    AST_FIRST_IS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == HDR_WORD)); // R3
    AST_NO_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !req_hit) |=> !tx_valid); // R2
endmodule

// File: tb/sim_stpkt_top.sv
`timescale 1ns/1ps
module sim_stpkt_top;
    localparam logic [31:0] HDR = 32'hC0DE_0A11;
    localparam logic [31:0] FTR = 32'hE0F0_55AA;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_strobe;
    logic [7:0]   cmd_opcode;
    logic [159:0] gen_status;
    logic         st_busy;
    logic [7:0]   st_detail;
    logic [4:0]   st_flags;
    logic         tx_ready;
    logic [31:0]  tx_data;
    logic         tx_valid;
    logic         tx_last;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    bit          rmode = 1'b0;
    string       cur_tag = "R3";
    logic [31:0] expq[$];
    int          wi = 0;
    bit          prev_v = 1'b0;
    bit          prev_r = 1'b0;
    logic [31:0] prev_d = '0;
    bit          prev_l = 1'b0;

    always #4 clk = ~clk;

    stpkt_top #(
        .OP_MAIN  (8'h30),
        .OP_ALIAS (8'h31),
        .HDR_WORD (HDR),
        .FTR_WORD (FTR)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_strobe (cmd_strobe),
        .cmd_opcode (cmd_opcode),
        .gen_status (gen_status),
        .st_busy    (st_busy),
        .st_detail  (st_detail),
        .st_flags   (st_flags),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_req(input logic [7:0] op);
        return (op == 8'h30) || (op == 8'h31);
    endfunction

    function automatic logic [31:0] selftest_word(input logic b, input logic [7:0] d, input logic [4:0] f);
        logic [31:0] w;
        w = '0;
        w[13]   = b;
        w[12:5] = d;
        w[4:0]  = f;
        return w;
    endfunction

    task automatic push_pkt();
        expq.push_back(HDR);
        for (int i = 0; i < 5; i++) expq.push_back(gen_status[32*i +: 32]);
        expq.push_back(selftest_word(st_busy, st_detail, st_flags));
        expq.push_back(FTR);
    endtask

    task automatic rand_stat();
        for (int i = 0; i < 5; i++) gen_status[32*i +: 32] = $urandom;
        st_busy   = 1'($urandom);
        st_detail = 8'($urandom);
        st_flags  = 5'($urandom);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (!tx_valid && expq.size() == 0) break;
        end
    endtask

    // monitor: decides ready, scores words that will transfer at the next rising edge
    always @(negedge clk) begin
        bit nr;
        logic [31:0] e;
        if (rst_n) begin
            if (prev_v && !prev_r) begin
                chk(tx_valid && tx_data == prev_d && tx_last == prev_l, "R6 stall hold", tx_data, prev_d);
            end
            nr = rmode ? (($urandom % 3) != 0) : 1'b1;
            tx_ready = nr;
            if (tx_valid && nr) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unrequested word", tx_data, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(tx_data == e, (wi == 5) ? "R4 self-test word" : cur_tag, tx_data, e);
                    chk(tx_last == (wi == 7), "R7 last flag", 32'(tx_last), 32'(wi == 7));
                    wi = (wi + 1) % 8;
                end
            end else if (tx_valid) begin
                chk(tx_last == (wi == 7), "R7 last flag", 32'(tx_last), 32'(wi == 7));
            end
            prev_v = tx_valid;
            prev_r = nr;
            prev_d = tx_data;
            prev_l = tx_last;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        cmd_strobe = 1'b0;
        cmd_opcode = 8'h00;
        tx_ready = 1'b0;
        rand_stat();
        repeat (3) @(negedge clk);
        chk(!tx_valid && !tx_last, "R1 reset outputs", {30'd0, tx_valid, tx_last}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!tx_valid && !tx_last, "R1 idle after reset", {30'd0, tx_valid, tx_last}, 32'd0);

        // R5 / R3: primary opcode, header one edge later
        cur_tag = "R3 record word";
        push_pkt();
        cmd_strobe = 1'b1; cmd_opcode = 8'h30;
        @(negedge clk);
        cmd_strobe = 1'b0;
        chk(tx_valid && tx_data == HDR, "R5 header latency", tx_data, HDR);
        wait_idle();

        // R2: alias opcode gives same record
        cur_tag = "R2 alias record";
        rand_stat();
        push_pkt();
        cmd_strobe = 1'b1; cmd_opcode = 8'h31;
        @(negedge clk);
        cmd_strobe = 1'b0;
        wait_idle();

        // R2: other opcodes and strobe low are ignored
        cmd_opcode = 8'h32; cmd_strobe = 1'b1; @(negedge clk);
        cmd_opcode = 8'hB1; @(negedge clk);
        cmd_opcode = 8'h00; @(negedge clk);
        cmd_opcode = 8'h30; cmd_strobe = 1'b0; @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!tx_valid, "R2 ignored opcodes", 32'(tx_valid), 32'd0);

        // R8: inputs change while the record is sent under back-pressure
        cur_tag = "R8 captured record";
        rmode = 1'b1;
        rand_stat();
        push_pkt();
        cmd_strobe = 1'b1; cmd_opcode = 8'h30;
        @(negedge clk);
        cmd_strobe = 1'b0;
        for (int k = 0; k < 12; k++) begin
            rand_stat();
            @(negedge clk);
        end
        wait_idle();
        rmode = 1'b0;
        @(negedge clk);

        // R9: requests during a record, merged, no gap
        cur_tag = "R9 queued record";
        rand_stat();
        push_pkt();
        cmd_strobe = 1'b1; cmd_opcode = 8'h30;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            cmd_strobe = 1'b0;
            if (k == 3) begin
                rand_stat();
                push_pkt();
                cmd_strobe = 1'b1; cmd_opcode = 8'h31;
            end
            if (k == 5) begin
                cmd_strobe = 1'b1; cmd_opcode = 8'h30;
            end
            if (k <= 16) chk(tx_valid, "R9 no idle gap", 32'(tx_valid), 32'd1);
            else         chk(!tx_valid, "R9 single extra record", 32'(tx_valid), 32'd0);
        end
        wait_idle();

        // R10: request exactly in the footer transfer cycle
        cur_tag = "R10 footer-cycle record";
        rand_stat();
        push_pkt();
        cmd_strobe = 1'b1; cmd_opcode = 8'h30;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            cmd_strobe = 1'b0;
            if (k == 8) begin
                chk(tx_last, "R10 footer cycle", 32'(tx_last), 32'd1);
                push_pkt();
                cmd_strobe = 1'b1; cmd_opcode = 8'h31;
            end
            if (k == 9) chk(tx_valid && tx_data == HDR, "R10 immediate header", tx_data, HDR);
            if (k == 17) chk(!tx_valid, "R10 ends", 32'(tx_valid), 32'd0);
        end
        wait_idle();

        // random mix under random back-pressure
        cur_tag = "R3 random record";
        rmode = 1'b1;
        for (int it = 0; it < 30; it++) begin
            logic [7:0] op;
            case ($urandom % 3)
                0: op = 8'h30;
                1: op = 8'h31;
                default: op = 8'($urandom);
            endcase
            rand_stat();
            if (is_req(op)) push_pkt();
            cmd_strobe = 1'b1; cmd_opcode = op;
            @(negedge clk);
            cmd_strobe = 1'b0;
            wait_idle();
            repeat (2) @(negedge clk);
        end
        rmode = 1'b0;
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R3 all words delivered", 32'(expq.size()), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule